// File: doc/BRIEF.md
# Hundredths-Resolution Time and Calendar Counter

This block keeps the time of day and the calendar date from a 32.768 kHz clock-enable. A phase accumulator turns that enable rate into exactly 100 ticks per second. Each tick advances a chain of BCD counters: hundredths, seconds, minutes, hours, day of month, month and two-digit year. A separate day-of-week counter runs beside the chain. The block drives two single-cycle strobes, one at 100 Hz and one at 1 Hz, for neighbouring logic.

A host presents a complete time and date on the load inputs and raises `wr_en`. Every field is written on that clock edge. For as long as `wr_en` stays high the counters and strobes stay frozen and the fractional phase is held at zero. All fields can be read at any time on the output ports, which come straight from registers.

Top module: `tk_timekeeper`

## Requirements
- R1: After a synchronous reset, hundredths, seconds, minutes, hours, day of week and year read 0 (BCD 0x00, day of week 0), day of month and month read 0x01, and both strobes are low.
- R2: `tick_100hz` is a one-cycle pulse. After a load, the first pulse comes on the 328th cycle with `osc_en` high, and any 32768 such cycles give exactly 100 pulses.
- R3: Hundredths advance by one in BCD on the edge that raises `tick_100hz` and do not change on any other edge.
- R4: Hundredths roll from 0x99 to 0x00 and carry into seconds. `tick_1hz` goes high in that same cycle, together with `tick_100hz`.
- R5: Seconds and minutes count 0x00 to 0x59, then wrap to 0x00 and carry.
- R6: Hours count 0x00 to 0x23. The wrap to 0x00 advances the day of month and the day of week.
- R7: Day of week counts 0 to 6 and wraps from 6 to 0.
- R8: Months 0x04, 0x06, 0x09 and 0x11 end after day 0x30. Months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12 end after day 0x31. The next day is 0x01 of the next month.
- R9: February ends after day 0x29 when the year (BCD 0x00 to 0x99) is divisible by 4, including 0x00. In other years it ends after day 0x28.
- R10: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R11: With `wr_en` high, every field takes its load value on that edge, the fractional phase is cleared, no strobe fires and no field counts, whatever `osc_en` is.
- R12: With `osc_en` low and `wr_en` low, no field changes and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Clock-enable at 32.768 kHz |
| wr_en | input | 1 | Host load; holds the counters while high |
| wr_hsec | input | 8 | Load value, hundredths (BCD) |
| wr_sec | input | 8 | Load value, seconds (BCD) |
| wr_min | input | 8 | Load value, minutes (BCD) |
| wr_hour | input | 8 | Load value, hours 00-23 (BCD) |
| wr_dow | input | 3 | Load value, day of week 0-6 |
| wr_day | input | 8 | Load value, day of month (BCD) |
| wr_mon | input | 8 | Load value, month (BCD) |
| wr_year | input | 8 | Load value, year 00-99 (BCD) |
| hsec | output | 8 | Hundredths of a second (BCD) |
| sec | output | 8 | Seconds (BCD) |
| minute | output | 8 | Minutes (BCD) |
| hour | output | 8 | Hours (BCD) |
| dow | output | 3 | Day of week |
| day | output | 8 | Day of month (BCD) |
| mon | output | 8 | Month (BCD) |
| year | output | 8 | Year (BCD) |
| tick_100hz | output | 1 | One-cycle strobe on each hundredths step |
| tick_1hz | output | 1 | One-cycle strobe on each seconds step |

## Verification
The bench loads the last hundredth of the last day of February in years 00, 23, 24, 96 and 98, of 30- and 31-day months, and of year 99. A wrong leap test or month table would land on day 0x29, 0x30, 0x31 or 0x01 when another was due. A wrong year wrap would show 0x9A or 0xA0. It counts enables from a load to the first 100 Hz strobe and over a whole 32768-enable window. An accumulator that drifts, or one that load does not clear, misses 328 or 100. Random loads biased toward rollover, random enable gaps and held writes show whether a design counts during a write or on idle cycles, or puts the 1 Hz strobe one cycle off the hundredths wrap.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;
  localparam int NFLD   = 7;
  localparam int F_HSEC = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DAY  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [7:0] bcd8_t;

  // Add one to a two-digit BCD value.
  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + o is congruent to 2*t + o modulo 4.
  function automatic logic leap_yr(bcd8_t y);
    logic [4:0] s;
    s = 5'({y[7:4], 1'b0}) + 5'(y[3:0]);
    return (s[1:0] == 2'd0);
  endfunction

  function automatic bcd8_t last_day(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Highest value of each fixed-length field; the day field is dynamic.
  function automatic bcd8_t fixed_hi(int i);
    case (i)
      F_HSEC:  return 8'h99;
      F_SEC:   return 8'h59;
      F_MIN:   return 8'h59;
      F_HOUR:  return 8'h23;
      F_MON:   return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic bcd8_t field_lo(int i);
    return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/tk_bcd_field.sv
`timescale 1ns/1ps
module tk_bcd_field
  import tk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  bcd8_t lo,
  input  bcd8_t hi,
  input  logic  ld,
  input  bcd8_t ld_val,
  input  logic  inc,
  output bcd8_t val
);
  always_ff @(posedge clk) begin
    if (rst)       val <= lo;
    else if (ld)   val <= ld_val;
    else if (inc)  val <= (val >= hi) ? lo : bcd_inc(val);
  end
endmodule

// File: rtl/tk_wrap_cnt.sv
`timescale 1ns/1ps
module tk_wrap_cnt #(
  parameter int W   = 3,
  parameter int TOP = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (ld)  val <= ld_val;
    else if (inc) val <= (val >= W'(TOP)) ? '0 : val + W'(1);
  end
endmodule

// File: rtl/tk_frac_div.sv
`timescale 1ns/1ps
module tk_frac_div #(
  parameter int IN_HZ  = 32768,
  parameter int OUT_HZ = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int ACC_W = $clog2(IN_HZ);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;

  assign sum  = {1'b0, acc} + SUM_W'(OUT_HZ);
  assign tick = en && (sum >= SUM_W'(IN_HZ));

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= tick ? ACC_W'(sum - SUM_W'(IN_HZ)) : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/tk_cal_chain.sv
`timescale 1ns/1ps
module tk_cal_chain
  import tk_pkg::*;
#(
  parameter int DOW_W   = 3,
  parameter int DOW_TOP = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ld,
  input  bcd8_t            ld_f [NFLD],
  input  logic [DOW_W-1:0] ld_dow,
  output bcd8_t            cur  [NFLD],
  output logic [DOW_W-1:0] dow,
  output logic             sec_carry
);
  logic [NFLD-1:0] inc;

  assign inc[0] = step;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    bcd8_t hi_i;
    if (i == F_DAY) begin : g_dyn
      assign hi_i = last_day(cur[F_MON], cur[F_YEAR]);
    end else begin : g_fix
      assign hi_i = fixed_hi(i);
    end

    tk_bcd_field u_fld (
      .clk    (clk),
      .rst    (rst),
      .lo     (field_lo(i)),
      .hi     (hi_i),
      .ld     (ld),
      .ld_val (ld_f[i]),
      .inc    (inc[i]),
      .val    (cur[i])
    );

    if (i < NFLD - 1) begin : g_carry
      assign inc[i+1] = inc[i] & (cur[i] >= hi_i);
    end
  end

  tk_wrap_cnt #(.W(DOW_W), .TOP(DOW_TOP)) u_dow (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .ld_val (ld_dow),
    .inc    (inc[F_DAY]),
    .val    (dow)
  );

  assign sec_carry = inc[F_SEC];
endmodule

// File: rtl/tk_timekeeper.sv
`timescale 1ns/1ps
module tk_timekeeper
  import tk_pkg::*;
#(
  parameter int IN_HZ  = 32768,
  parameter int OUT_HZ = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [7:0] wr_hsec,
  input  logic [7:0] wr_sec,
  input  logic [7:0] wr_min,
  input  logic [7:0] wr_hour,
  input  logic [2:0] wr_dow,
  input  logic [7:0] wr_day,
  input  logic [7:0] wr_mon,
  input  logic [7:0] wr_year,
  output logic [7:0] hsec,
  output logic [7:0] sec,
  output logic [7:0] minute,
  output logic [7:0] hour,
  output logic [2:0] dow,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] year,
  output logic       tick_100hz,
  output logic       tick_1hz
);
  logic  step, sec_carry;
  bcd8_t ld_f [NFLD];
  bcd8_t cur  [NFLD];

  assign ld_f[F_HSEC] = wr_hsec;
  assign ld_f[F_SEC]  = wr_sec;
  assign ld_f[F_MIN]  = wr_min;
  assign ld_f[F_HOUR] = wr_hour;
  assign ld_f[F_DAY]  = wr_day;
  assign ld_f[F_MON]  = wr_mon;
  assign ld_f[F_YEAR] = wr_year;

  tk_frac_div #(.IN_HZ(IN_HZ), .OUT_HZ(OUT_HZ)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (wr_en),
    .en   (osc_en & ~wr_en),
    .tick (step)
  );

  tk_cal_chain #(.DOW_W(3), .DOW_TOP(6)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .ld        (wr_en),
    .ld_f      (ld_f),
    .ld_dow    (wr_dow),
    .cur       (cur),
    .dow       (dow),
    .sec_carry (sec_carry)
  );

  assign hsec   = cur[F_HSEC];
  assign sec    = cur[F_SEC];
  assign minute = cur[F_MIN];
  assign hour   = cur[F_HOUR];
  assign day    = cur[F_DAY];
  assign mon    = cur[F_MON];
  assign year   = cur[F_YEAR];

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_100hz <= 1'b0;
      tick_1hz   <= 1'b0;
    end else begin
      tick_100hz <= step;
      tick_1hz   <= sec_carry;
    end
  end
endmodule

// File: rtl/tk_timekeeper_chk.sv
`timescale 1ns/1ps
module tk_timekeeper_chk (
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic       wr_en,
  input logic [7:0] hsec,
  input logic [7:0] sec,
  input logic [2:0] dow,
  input logic       tick_100hz,
  input logic       tick_1hz
);
  a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
    tick_100hz |-> ($past(osc_en) && !$past(wr_en)));

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick_100hz |=> (!tick_100hz || $past(osc_en) == 1'b1));

  a_r3_hsec_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick_100hz && !$past(wr_en)) |-> $stable(hsec));

  a_r4_second_on_wrap: assert property (@(posedge clk) disable iff (rst)
    tick_1hz |-> (tick_100hz && hsec == 8'h00));

  a_r5_sec_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    ((sec != $past(sec)) && !$past(wr_en)) |-> tick_1hz);

  a_r7_dow_step: assert property (@(posedge clk) disable iff (rst)
    ((dow != $past(dow)) && !$past(wr_en)) |->
      (dow == (($past(dow) >= 3'd6) ? 3'd0 : 3'($past(dow) + 3'd1))));

  a_r11_quiet_in_write: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (!tick_100hz && !tick_1hz));

  a_r12_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !$past(osc_en) |-> !tick_100hz);
endmodule

bind tk_timekeeper tk_timekeeper_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .osc_en     (osc_en),
  .wr_en      (wr_en),
  .hsec       (hsec),
  .sec        (sec),
  .dow        (dow),
  .tick_100hz (tick_100hz),
  .tick_1hz   (tick_1hz)
);

// File: tb/tb_tk_timekeeper.sv
`timescale 1ns/1ps
module tb_tk_timekeeper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_hsec = '0, wr_sec = '0, wr_min = '0, wr_hour = '0;
  logic [7:0] wr_day = '0, wr_mon = '0, wr_year = '0;
  logic [2:0] wr_dow = '0;
  logic [7:0] hsec, sec, minute, hour, day, mon, year;
  logic [2:0] dow;
  logic tick_100hz, tick_1hz;

  always #2.5 clk = ~clk;

  tk_timekeeper dut (.*);

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;
  int m_hs, m_sc, m_mi, m_hr, m_dw, m_dy, m_mo, m_yr, m_acc;
  bit m_s100, m_s1;
  int l_hs, l_sc, l_mi, l_hr, l_dw, l_dy, l_mo, l_yr;

  function automatic int bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic m_tick();
    m_s100 = 1'b1;
    m_hs++;
    if (m_hs == 100) begin
      m_hs = 0; m_s1 = 1'b1; m_sc++;
      if (m_sc == 60) begin
        m_sc = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_dw = (m_dw == 6) ? 0 : m_dw + 1;
            m_dy++;
            if (m_dy > dim(m_mo, m_yr)) begin
              m_dy = 1; m_mo++;
              if (m_mo == 13) begin
                m_mo = 1; m_yr = (m_yr + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic compare_all();
    chk(int'(hsec)   == bcd(m_hs), "R3 hsec",   int'(hsec),   bcd(m_hs));
    chk(int'(sec)    == bcd(m_sc), "R5 sec",    int'(sec),    bcd(m_sc));
    chk(int'(minute) == bcd(m_mi), "R5 minute", int'(minute), bcd(m_mi));
    chk(int'(hour)   == bcd(m_hr), "R6 hour",   int'(hour),   bcd(m_hr));
    chk(int'(dow)    == m_dw,      "R7 dow",    int'(dow),    m_dw);
    chk(int'(day)    == bcd(m_dy), "R8 day",    int'(day),    bcd(m_dy));
    chk(int'(mon)    == bcd(m_mo), "R10 mon",   int'(mon),    bcd(m_mo));
    chk(int'(year)   == bcd(m_yr), "R10 year",  int'(year),   bcd(m_yr));
    chk(tick_100hz == m_s100, "R2 tick_100hz", int'(tick_100hz), int'(m_s100));
    chk(tick_1hz   == m_s1,   "R4 tick_1hz",   int'(tick_1hz),   int'(m_s1));
  endtask

  // Drive at the falling edge, update the model after the rising edge,
  // compare at the next falling edge.
  task automatic cyc(bit en, bit wr);
    osc_en = en; wr_en = wr;
    @(posedge clk);
    cycles++;
    m_s100 = 1'b0; m_s1 = 1'b0;
    if (wr) begin
      m_hs = l_hs; m_sc = l_sc; m_mi = l_mi; m_hr = l_hr;
      m_dw = l_dw; m_dy = l_dy; m_mo = l_mo; m_yr = l_yr; m_acc = 0;
    end else if (en) begin
      m_acc += 100;
      if (m_acc >= 32768) begin
        m_acc -= 32768;
        m_tick();
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_load(int hs, int sc, int mi, int hr, int dw, int dy, int mo, int yr);
    l_hs = hs; l_sc = sc; l_mi = mi; l_hr = hr; l_dw = dw; l_dy = dy; l_mo = mo; l_yr = yr;
    wr_hsec = 8'(bcd(hs)); wr_sec = 8'(bcd(sc)); wr_min = 8'(bcd(mi)); wr_hour = 8'(bcd(hr));
    wr_dow = 3'(dw); wr_day = 8'(bcd(dy)); wr_mon = 8'(bcd(mo)); wr_year = 8'(bcd(yr));
  endtask

  // Load the last hundredth before midnight and run to the first strobe.
  task automatic midnight(int dw, int dy, int mo, int yr, int edy, int emo, int eyr, string tag);
    set_load(99, 59, 59, 23, dw, dy, mo, yr);
    cyc(1'b1, 1'b1);
    for (int k = 0; k < 328; k++) cyc(1'b1, 1'b0);
    chk(int'(day) == bcd(edy), tag, int'(day), bcd(edy));
    chk(int'(mon) == bcd(emo), tag, int'(mon), bcd(emo));
    chk(int'(year) == bcd(eyr), tag, int'(year), bcd(eyr));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (cycles > 190000 || $time > 64'd1100000) begin
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin : main
    int first, cnt, dy, mo, yr;
    void'($urandom(32'd20240611));
    m_hs = 0; m_sc = 0; m_mi = 0; m_hr = 0; m_dw = 0; m_dy = 1; m_mo = 1; m_yr = 0;
    m_acc = 0; m_s100 = 0; m_s1 = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    compare_all();
    chk(day == 8'h01 && mon == 8'h01, "R1 reset date", int'({day, mon}), 16'h0101);

    // R12: no enable, nothing moves
    for (int k = 0; k < 500; k++) cyc(1'b0, 1'b0);
    chk(hsec == 8'h00 && !tick_100hz, "R12 idle", int'(hsec), 0);

    // R11: held write, counters frozen
    set_load(78, 56, 34, 12, 3, 15, 7, 42);
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1);
    chk(hsec == 8'h78 && sec == 8'h56 && dow == 3'd3, "R11 held load", int'(hsec), 'h78);

    // R2: first strobe at enable 328, 100 strobes in 32768 enables
    first = 0; cnt = 0;
    for (int k = 1; k <= 32768; k++) begin
      cyc(1'b1, 1'b0);
      if (tick_100hz) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    chk(first == 328, "R2 first strobe", first, 328);
    chk(cnt == 100, "R2 strobes per window", cnt, 100);

    // R11: a load clears the fractional phase mid-way
    for (int k = 0; k < 200; k++) cyc(1'b1, 1'b0);
    set_load(0, 0, 0, 0, 0, 1, 1, 0);
    cyc(1'b1, 1'b1);
    first = 0;
    for (int k = 1; k <= 330; k++) begin
      cyc(1'b1, 1'b0);
      if (tick_100hz && first == 0) first = k;
    end
    chk(first == 328, "R11 phase cleared", first, 328);

    // R9 leap years, R8 month ends, R10 year wrap, R6/R7 day rollover
    midnight(2, 28, 2, 24, 29, 2, 24, "R9 leap 24");
    midnight(2, 28, 2, 0, 29, 2, 0, "R9 leap 00");
    midnight(2, 28, 2, 96, 29, 2, 96, "R9 leap 96");
    midnight(2, 28, 2, 23, 1, 3, 23, "R9 common 23");
    midnight(2, 28, 2, 98, 1, 3, 98, "R9 common 98");
    midnight(2, 29, 2, 24, 1, 3, 24, "R9 leap end");
    midnight(4, 30, 4, 50, 1, 5, 50, "R8 april end");
    midnight(4, 30, 5, 50, 31, 5, 50, "R8 may 31");
    midnight(4, 30, 11, 7, 1, 12, 7, "R8 nov end");
    midnight(6, 31, 12, 99, 1, 1, 0, "R10 year wrap");
    chk(dow == 3'd0 && hour == 8'h00, "R7 dow wrap", int'(dow), 0);
    chk(sec == 8'h00 && minute == 8'h00, "R6 midnight", int'({sec, minute}), 0);

    // Random loads biased toward rollover, random enable gaps and writes
    for (int it = 0; it < 40; it++) begin
      mo = 1 + int'($urandom_range(11));
      yr = int'($urandom_range(99));
      dy = ($urandom_range(1) == 1) ? dim(mo, yr) : 1 + int'($urandom_range(dim(mo, yr) - 1));
      set_load(($urandom_range(1) == 1) ? 99 : int'($urandom_range(99)),
               ($urandom_range(1) == 1) ? 59 : int'($urandom_range(59)),
               ($urandom_range(1) == 1) ? 59 : int'($urandom_range(59)),
               ($urandom_range(1) == 1) ? 23 : int'($urandom_range(23)),
               int'($urandom_range(6)), dy, mo, yr);
      cyc($urandom_range(1) == 1, 1'b1);
      for (int k = 0; k < 500 + int'($urandom_range(300)); k++)
        cyc($urandom_range(3) != 0, $urandom_range(255) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule